// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This unit adds or subtracts two operands held in signed-magnitude form. Each operand is a magnitude register paired with its own sign flip-flop. A single parallel adder does the arithmetic. A mode signal picks what the adder receives: the second magnitude as it is, or its one's complement with a carry-in of one. The adder's end carry is captured in a carry flip-flop E. A separate overflow flip-flop records a carry out of a magnitude addition.

A caller presents both operands and the operation, then pulses `start` for one cycle. The unit first folds the operation into the second sign. Equal signs lead to adding the magnitudes, and unequal signs lead to subtracting them. After a subtraction, E shows which magnitude was larger. If the second magnitude was larger, the unit re-complements the difference and flips the sign. A zero result is always reported as positive zero. `done` rises for one cycle, and the result stays on the outputs until the next accepted start.

Top module: `sm_addsub`

## Requirements
- R1: After reset, `done`, `res_sign`, `res_mag` and `ovf` are all 0.
- R2: An addition (`sub_op`=0) of operands with equal signs yields `res_mag` = a_mag + b_mag and `res_sign` = `a_sign` when no overflow occurs.
- R3: An effective magnitude subtraction where a_mag >= b_mag yields `res_mag` = a_mag - b_mag with `res_sign` = `a_sign` (unless the result is zero, see R7).
- R4: An effective magnitude subtraction where a_mag < b_mag yields `res_mag` = b_mag - a_mag with `res_sign` = inverse of `a_sign`.
- R5: For a subtraction (`sub_op`=1), `b_sign` is inverted first, and then the same rules as addition apply.
- R6: When an addition of magnitudes carries out of the W-bit field, `ovf` is 1 and `res_mag` holds the low W bits of the sum. `ovf` is 0 after any magnitude subtraction.
- R7: A result magnitude of zero is always reported with `res_sign` = 0 (1 means negative, 0 positive).
- R8: `done` is high for exactly one cycle. It appears three rising edges after the edge that samples `start` high in the idle state.
- R9: The result outputs stay constant from `done` until the next accepted start. A `start` raised while an operation is in progress is ignored and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| sub_op | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_mag | input | W | Magnitude of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_mag | input | W | Magnitude of operand B |
| done | output | 1 | One-cycle completion pulse |
| res_sign | output | 1 | Result sign |
| res_mag | output | W | Result magnitude |
| ovf | output | 1 | Magnitude addition overflow |

## Verification
Two cases are the hardest to reach from the ports. The first is the re-complement path, where E is clear after a subtraction. It happens only when the effective signs differ and the second magnitude is the larger one, so the stimulus reaches it both through additions of mixed signs and through subtractions of equal signs. The second is the zero-sign rule, which is only visible when magnitudes cancel or wrap. The stimulus therefore pairs +0 with -0, cancels equal magnitudes of opposite effective sign, and adds two magnitudes whose sum wraps to exactly zero. A second start is raised while the unit is busy, with different operands, to show that it is dropped.

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sub_op,
  input  logic         a_sign,
  input  logic [W-1:0] a_mag,
  input  logic         b_sign,
  input  logic [W-1:0] b_mag,
  output logic         done,
  output logic         res_sign,
  output logic [W-1:0] res_mag,
  output logic         ovf
);

  typedef enum logic [1:0] {S_IDLE, S_ADD, S_FIX} st_t;

  st_t         st;
  logic [W-1:0] ra, rb;
  logic         as_q, bs_q, e_q, aof_q, m_q;

  wire          mode = as_q ^ bs_q;
  wire [W-1:0]  bop  = mode ? ~rb : rb;
  wire [W:0]    sum  = {1'b0, ra} + {1'b0, bop} + (W+1)'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ra    <= '0;
      rb    <= '0;
      as_q  <= 1'b0;
      bs_q  <= 1'b0;
      e_q   <= 1'b0;
      aof_q <= 1'b0;
      m_q   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ra    <= a_mag;
          rb    <= b_mag;
          as_q  <= a_sign;
          bs_q  <= b_sign ^ sub_op;
          st    <= S_ADD;
        end
        S_ADD: begin
          {e_q, ra} <= sum;
          aof_q     <= !mode && sum[W];
          m_q       <= mode;
          st        <= S_FIX;
        end
        S_FIX: begin
          if (m_q && !e_q) begin
            ra   <= -ra;
            as_q <= ~as_q;
          end
          if (ra == '0) as_q <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign res_mag  = ra;
  assign res_sign = as_q;
  assign ovf      = aof_q;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_IDLE) |-> ##3 done);

  a_r7_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_mag == '0) |-> !res_sign);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> $stable({res_sign, res_mag, ovf}));

  a_r4_recomplement: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX && m_q && !e_q) |=>
      (res_mag == W'(-$past(res_mag)) && res_sign != $past(res_sign)));

  a_r6_sub_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_q) |-> !ovf);

endmodule

// File: tb/tb_sm_addsub.sv
`timescale 1ns/1ps
module tb_sm_addsub;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sub_op = 1'b0;
  logic         a_sign = 1'b0;
  logic [W-1:0] a_mag = '0;
  logic         b_sign = 1'b0;
  logic [W-1:0] b_mag = '0;
  logic         done;
  logic         res_sign;
  logic [W-1:0] res_mag;
  logic         ovf;

  sm_addsub #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub_op(sub_op),
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .done(done), .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic prev_done = 1'b0;

  logic [W+1:0] exp_q[$];
  int           stamp_q[$];
  string        tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // expected {sign, mag, ovf}
  function automatic logic [W+1:0] model(input logic s, input logic as_,
                                         input logic [W-1:0] am, input logic bs_,
                                         input logic [W-1:0] bm);
    int x, y, m;
    logic sg, ov;
    x = int'(am); y = int'(bm); ov = 1'b0;
    if (as_ == (bs_ ^ s)) begin
      m = x + y; sg = as_;
      if (m >= (1 << W)) begin ov = 1'b1; m = m - (1 << W); end
    end else if (x >= y) begin
      m = x - y; sg = as_;
    end else begin
      m = y - x; sg = ~as_;
    end
    if (m == 0) sg = 1'b0;
    return {sg, W'(m), ov};
  endfunction

  task automatic check(input string tag, input logic [W+1:0] got, input logic [W+1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got sign=%0b mag=%0d ovf=%0b, expected sign=%0b mag=%0d ovf=%0b",
               tag, got[W+1], got[W:1], got[0], exp[W+1], exp[W:1], exp[0]);
    end
  endtask

  task automatic issue(input logic s, input logic as_, input logic [W-1:0] am,
                       input logic bs_, input logic [W-1:0] bm, input string tag);
    @(negedge clk);
    sub_op = s; a_sign = as_; a_mag = am; b_sign = bs_; b_mag = bm;
    start = 1'b1;
    exp_q.push_back(model(s, as_, am, bs_, bm));
    stamp_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic run(input logic s, input logic as_, input logic [W-1:0] am,
                     input logic bs_, input logic [W-1:0] bm, input string tag);
    issue(s, as_, am, bs_, bm, tag);
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) begin
        checks++; fails++;
        $display("FAIL R8: done high two cycles in a row, got 1 expected 0");
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9: unexpected done, got 1 expected 0");
        end else begin
          logic [W+1:0] e;
          int st_c;
          string t;
          e = exp_q.pop_front(); st_c = stamp_q.pop_front(); t = tag_q.pop_front();
          check(t, {res_sign, res_mag, ovf}, e);
          checks++;
          if (cyc - st_c != 3) begin
            fails++;
            $display("FAIL R8: latency got %0d expected 3", cyc - st_c);
          end
        end
      end
    end
    prev_done <= done;
  end

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W+1:0] held;
    repeat (3) @(negedge clk);
    check("R1", {done, res_sign, res_mag[W-2:0], ovf} , '0);
    check("R1", {res_sign, res_mag, ovf}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run(0, 0, 20, 0, 30, "R2");
    run(0, 1, 100, 1, 27, "R2");
    run(0, 0, 50, 1, 20, "R3");
    run(0, 1, 90, 0, 15, "R3");
    run(0, 0, 20, 1, 50, "R4");
    run(0, 1, 3, 0, 200, "R4");
    run(1, 0, 50, 0, 20, "R5");
    run(1, 0, 20, 0, 50, "R5");
    run(1, 1, 10, 1, 40, "R5");
    run(1, 1, 60, 0, 70, "R5");
    run(0, 0, 200, 0, 100, "R6");
    run(1, 0, 200, 1, 100, "R6");
    run(0, 0, 255, 1, 1, "R6");
    run(1, 0, 255, 0, 255, "R7");
    run(0, 0, 0, 1, 0, "R7");
    run(0, 1, 5, 0, 5, "R7");
    run(0, 1, 128, 1, 128, "R7");
    run(1, 1, 0, 1, 0, "R7");

    // start while busy is ignored
    issue(0, 0, 11, 0, 22, "R9");
    @(negedge clk);
    a_mag = 99; b_mag = 1; sub_op = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);

    // results hold while idle and inputs move
    held = {res_sign, res_mag, ovf};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a_mag = W'(i * 37); b_mag = W'(i * 11); a_sign = i[0]; b_sign = i[1];
    end
    check("R9", {res_sign, res_mag, ovf}, held);
    check("R9", {done, 1'b0, {W{1'b0}}}, '0);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8: missing done, got %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule